// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a CPU and decides which interrupt request the processor services next. It gathers sixteen prioritized request lines and two special events: reset and a software interrupt. Each request line is the OR of several flag/enable pairs. Line 1 comes from a falling-edge latch on an external active-low request pin. Line 2 comes from a flag that sets whenever a clock PLL gains or loses lock. Lines 3 to 16 are built from flag/enable pairs that the peripherals supply. A global mask input, the CPU's I bit, blocks every line. It does not block the software interrupt.

The chosen request is turned into a 16-bit vector fetch address. The address and the priority number leave the block on a valid/ready stream. While `vec_valid_o` is high and `vec_ready_i` is low, the address and the priority are frozen, so the CPU can fetch both vector bytes from a stable address. A transfer completes on a cycle where valid and ready are both high. On the next cycle the register reloads from the current arbitration. Valid is low only when nothing is requestable. A plain `irq_req_o` level tells the CPU that an unmasked line is pending. A readback vector `pend_o` shows every line's pending state, before the global mask is applied.

Top module: `intc_vector_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the stream presents the reset vector, with address 0xFFFE, priority 0 and valid high, until it is accepted. `irq_req_o` is low and `pend_o` is zero after reset.
- R2: The high vector byte sits at the following addresses: 0xFFFE for reset, 0xFFFC for the software interrupt, and 0xFFFC minus 2·p for line p (1..16). Line 1 therefore uses 0xFFFA and line 16 uses 0xFFDC. The low byte is at the next address. `vec_prio_o` is 0 for reset and for the software interrupt, and p for line p.
- R3: Line p (3..16) is pending when at least one of its four flag/enable pairs has both bits high. The pair at bit (p-3)*4+k of `per_flag_i`/`per_en_i` belongs to line p. `pend_o` bit p-1 shows line p.
- R4: The order of precedence is reset, then the software interrupt, then the lowest-numbered pending line.
- R5: While `i_mask_i` is high, no line produces a vector or `irq_req_o`, and `pend_o` still shows the pending lines.
- R6: A one-cycle `swi_i` pulse is latched. It is presented with address 0xFFFC whatever the value of `i_mask_i`. Accepting that vector clears the latched pulse.
- R7: Each falling edge on `irq_pin_ni` sets the line-1 latch exactly once, after a two-flop synchronizer. A pulse on `irq_ack_i` clears the latch, and it stays clear while the pin remains low. Line 1 is pending when the latch is set and `irq_mask_i` is low. Masking keeps the latch.
- R8: The PLL flag sets on every change of `pll_lock_i`, in either direction, and a pulse on `pll_ack_i` clears it. Line 2 is pending when the flag and `pll_ie_i` are both high.
- R9: While `vec_valid_o` is high and `vec_ready_i` is low, `vec_addr_o` and `vec_prio_o` hold their values. A higher-priority request that arrives in that time does not change them.
- R10: `irq_req_o` is high one cycle after some line is pending while `i_mask_i` is low, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| i_mask_i | input | 1 | Global interrupt mask (CPU I bit) |
| swi_i | input | 1 | Software interrupt request pulse |
| irq_pin_ni | input | 1 | External active-low request pin, asynchronous |
| irq_mask_i | input | 1 | Mask for the pin latch |
| irq_ack_i | input | 1 | Write-one clear of the pin latch |
| pll_lock_i | input | 1 | PLL lock status |
| pll_ie_i | input | 1 | PLL change interrupt enable |
| pll_ack_i | input | 1 | Write-one clear of the PLL flag |
| per_flag_i | input | 56 | Peripheral flags, four per line for lines 3..16 |
| per_en_i | input | 56 | Peripheral enables matching `per_flag_i` |
| pend_o | output | 16 | Pending readback, bit p-1 is line p |
| irq_req_o | output | 1 | Unmasked interrupt request to the CPU |
| vec_valid_o | output | 1 | Vector stream valid |
| vec_ready_i | input | 1 | Vector stream ready (CPU fetches) |
| vec_addr_o | output | 16 | Vector high-byte address |
| vec_prio_o | output | 5 | Priority number of the presented vector |

## Verification
The assertions assume that `vec_ready_i` is a clean synchronous level from the CPU and that `swi_i` is a single-cycle pulse. They also assume that the flag, enable, mask and acknowledge inputs change only between clock edges. Only `irq_pin_ni` may change at any time. The bench drives every input on the falling clock edge. It keeps `vec_ready_i` low unless it is deliberately completing a transfer. It pulses `swi_i` and the acknowledge inputs for exactly one cycle, so the hold and software-interrupt properties are exercised only under the conditions they rely on.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int unsigned VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFE;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_RESET = 2'd1,
    SRC_SWI   = 2'd2,
    SRC_LINE  = 2'd3
  } src_kind_e;

  // Vector slot: 0 reset, 1 software interrupt, p+1 for line p.
  function automatic logic [VEC_W-1:0] slot_addr(input int unsigned slot);
    return VEC_TOP - VEC_W'(2 * slot);
  endfunction

endpackage

// File: rtl/intc_irq_edge.sv
module intc_irq_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic ack_i,
  output logic latch_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   latch_q;
  logic                   fall;

  // Idle level of the pin is high, so the chain resets to ones.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_ni};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];

  // A new edge wins over an acknowledge in the same cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= 1'b0;
    else         latch_q <= fall | (latch_q & ~ack_i);
  end

  assign latch_o = latch_q;

endmodule

// File: rtl/intc_pll_flag.sv
module intc_pll_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic ack_i,
  output logic flag_o
);

  logic lock_q;
  logic primed_q;
  logic flag_q;
  logic change;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lock_q   <= lock_i;
      primed_q <= 1'b1;
    end
  end

  // The first sample after reset only establishes the reference level.
  assign change = primed_q & (lock_i ^ lock_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= change | (flag_q & ~ack_i);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/intc_line_merge.sv
module intc_line_merge #(
  parameter int unsigned LINES = 14,
  parameter int unsigned PAIRS = 4,
  localparam int unsigned W = LINES * PAIRS
) (
  input  logic [W-1:0]     flag_i,
  input  logic [W-1:0]     en_i,
  output logic [LINES-1:0] line_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_o[g] = |(flag_i[g*PAIRS +: PAIRS] & en_i[g*PAIRS +: PAIRS]);
  end

endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [LINES-1:0] req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);

  // Lowest index wins: scan downward so the last match is the smallest.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/intc_vector_ctrl.sv
module intc_vector_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 16,
  parameter int unsigned PAIRS       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned EXT_LINES  = NUM_LINES - 2,
  localparam int unsigned PAIR_W     = EXT_LINES * PAIRS,
  localparam int unsigned PRIO_W     = $clog2(NUM_LINES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  i_mask_i,
  input  logic                  swi_i,
  input  logic                  irq_pin_ni,
  input  logic                  irq_mask_i,
  input  logic                  irq_ack_i,
  input  logic                  pll_lock_i,
  input  logic                  pll_ie_i,
  input  logic                  pll_ack_i,
  input  logic [PAIR_W-1:0]     per_flag_i,
  input  logic [PAIR_W-1:0]     per_en_i,
  output logic [NUM_LINES-1:0]  pend_o,
  output logic                  irq_req_o,
  output logic                  vec_valid_o,
  input  logic                  vec_ready_i,
  output logic [VEC_W-1:0]      vec_addr_o,
  output logic [PRIO_W-1:0]     vec_prio_o
);

  logic                 irq_latch;
  logic                 pll_flag;
  logic [EXT_LINES-1:0] ext_pend;
  logic [NUM_LINES-1:0] line_pend;
  logic [NUM_LINES-1:0] line_req;
  logic                 arb_hit;
  logic [PRIO_W-1:0]    arb_idx;

  intc_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_ni  (irq_pin_ni),
    .ack_i   (irq_ack_i),
    .latch_o (irq_latch)
  );

  intc_pll_flag u_pll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lock_i (pll_lock_i),
    .ack_i  (pll_ack_i),
    .flag_o (pll_flag)
  );

  intc_line_merge #(.LINES(EXT_LINES), .PAIRS(PAIRS)) u_merge (
    .flag_i (per_flag_i),
    .en_i   (per_en_i),
    .line_o (ext_pend)
  );

  assign line_pend = {ext_pend, pll_flag & pll_ie_i, irq_latch & ~irq_mask_i};
  assign line_req  = line_pend & {NUM_LINES{~i_mask_i}};
  assign pend_o    = line_pend;

  intc_prio_arb #(.LINES(NUM_LINES), .IDX_W(PRIO_W)) u_arb (
    .req_i (line_req),
    .hit_o (arb_hit),
    .idx_o (arb_idx)
  );

  // Stream register and one-shot event latches.
  logic              valid_q;
  src_kind_e         kind_q;
  logic [VEC_W-1:0]  addr_q;
  logic [PRIO_W-1:0] prio_q;
  logic              rst_pend_q;
  logic              swi_pend_q;
  logic              irq_req_q;

  logic              accept;
  logic              hold;
  logic              rst_pend_n;
  logic              swi_pend_n;
  src_kind_e         kind_n;
  logic [VEC_W-1:0]  addr_n;
  logic [PRIO_W-1:0] prio_n;

  assign accept = valid_q & vec_ready_i;
  assign hold   = valid_q & ~vec_ready_i;

  // Retire a one-shot on the cycle it is accepted so it is not re-presented.
  assign rst_pend_n = rst_pend_q & ~(accept & (kind_q == SRC_RESET));
  assign swi_pend_n = swi_i | (swi_pend_q & ~(accept & (kind_q == SRC_SWI)));

  always_comb begin
    kind_n = SRC_NONE;
    addr_n = slot_addr(0);
    prio_n = '0;
    if (rst_pend_n) begin
      kind_n = SRC_RESET;
      addr_n = slot_addr(0);
    end else if (swi_pend_n) begin
      kind_n = SRC_SWI;
      addr_n = slot_addr(1);
    end else if (arb_hit) begin
      kind_n = SRC_LINE;
      addr_n = slot_addr(int'(arb_idx) + 2);
      prio_n = arb_idx + PRIO_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_q <= 1'b1;
      swi_pend_q <= 1'b0;
    end else begin
      rst_pend_q <= rst_pend_n;
      swi_pend_q <= swi_pend_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b1;
      kind_q  <= SRC_RESET;
      addr_q  <= VEC_TOP;
      prio_q  <= '0;
    end else if (!hold) begin
      valid_q <= (kind_n != SRC_NONE);
      kind_q  <= kind_n;
      addr_q  <= addr_n;
      prio_q  <= prio_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_req_q <= 1'b0;
    else         irq_req_q <= |line_req;
  end

  assign irq_req_o   = irq_req_q;
  assign vec_valid_o = valid_q;
  assign vec_addr_o  = addr_q;
  assign vec_prio_o  = prio_q;

endmodule

// File: rtl/intc_vector_ctrl_chk.sv
module intc_vector_ctrl_chk
  import intc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned PRIO_W    = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 i_mask_i,
  input logic                 swi_i,
  input logic                 vec_ready_i,
  input logic                 vec_valid_o,
  input logic [VEC_W-1:0]     vec_addr_o,
  input logic [PRIO_W-1:0]    vec_prio_o,
  input logic [NUM_LINES-1:0] pend_o,
  input logic                 irq_req_o
);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_addr_o) && $stable(vec_prio_o)));

  // R2
  line_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_prio_o != '0) |-> (vec_addr_o == VEC_TOP - VEC_W'(2 * (int'(vec_prio_o) + 1))));

  // R2
  top_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_prio_o == '0) |-> (vec_addr_o == 16'hFFFE || vec_addr_o == 16'hFFFC));

  // R6
  swi_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swi_i && !(vec_valid_o && !vec_ready_i)) |=> (vec_valid_o && vec_prio_o == '0));

  // R10
  req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_mask_i || pend_o == '0) |=> !irq_req_o);

  // R5
  mask_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_mask_i && !swi_i && !(vec_valid_o && !vec_ready_i) && $stable(i_mask_i))
      |=> (!vec_valid_o || vec_prio_o == '0));

endmodule

bind intc_vector_ctrl intc_vector_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .PRIO_W    (PRIO_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .i_mask_i    (i_mask_i),
  .swi_i       (swi_i),
  .vec_ready_i (vec_ready_i),
  .vec_valid_o (vec_valid_o),
  .vec_addr_o  (vec_addr_o),
  .vec_prio_o  (vec_prio_o),
  .pend_o      (pend_o),
  .irq_req_o   (irq_req_o)
);

// File: tb/tb_intc_vector_ctrl.sv
`timescale 1ns/1ps
module tb_intc_vector_ctrl;

  localparam int unsigned NL   = 16;
  localparam int unsigned NP   = 4;
  localparam int unsigned PW   = (NL - 2) * NP;
  localparam int unsigned PRW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          i_mask = 1'b0;
  logic          swi = 1'b0;
  logic          irq_pin_n = 1'b1;
  logic          irq_mask = 1'b0;
  logic          irq_ack = 1'b0;
  logic          pll_lock = 1'b0;
  logic          pll_ie = 1'b0;
  logic          pll_ack = 1'b0;
  logic [PW-1:0] flag = '0;
  logic [PW-1:0] en = '0;
  logic [NL-1:0] pend;
  logic          irq_req;
  logic          vvalid;
  logic          vready = 1'b0;
  logic [15:0]   vaddr;
  logic [PRW-1:0] vprio;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_vector_ctrl dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .i_mask_i    (i_mask),
    .swi_i       (swi),
    .irq_pin_ni  (irq_pin_n),
    .irq_mask_i  (irq_mask),
    .irq_ack_i   (irq_ack),
    .pll_lock_i  (pll_lock),
    .pll_ie_i    (pll_ie),
    .pll_ack_i   (pll_ack),
    .per_flag_i  (flag),
    .per_en_i    (en),
    .pend_o      (pend),
    .irq_req_o   (irq_req),
    .vec_valid_o (vvalid),
    .vec_ready_i (vready),
    .vec_addr_o  (vaddr),
    .vec_prio_o  (vprio)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pidx(input int line, input int pair);
    return (line - 3) * NP + pair;
  endfunction

  function automatic logic [15:0] laddr(input int line);
    return 16'hFFFC - 16'(2 * line);
  endfunction

  // Remove all stimulus and complete transfers until the stream is empty.
  task automatic drain();
    flag = '0; en = '0; swi = 1'b0;
    vready = 1'b1;
    cyc(2);
    vready = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 valid during reset", 32'(vvalid), 32'd1);
    chk("R1 addr during reset", 32'(vaddr), 32'hFFFE);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 reset vector held", 32'(vaddr), 32'hFFFE);
    chk("R1 prio", 32'(vprio), 32'd0);
    chk("R1 irq_req low", 32'(irq_req), 32'd0);
    chk("R1 pend zero", 32'(pend), 32'd0);
    vready = 1'b1;
    cyc(1);
    vready = 1'b0;
    cyc(1);
    chk("R1 retired after accept", 32'(vvalid), 32'd0);
  endtask

  task automatic t_swi();
    i_mask = 1'b1;
    swi = 1'b1;
    cyc(1);
    swi = 1'b0;
    chk("R6 swi valid under mask", 32'(vvalid), 32'd1);
    chk("R6 R2 swi addr", 32'(vaddr), 32'hFFFC);
    chk("R6 irq_req stays low", 32'(irq_req), 32'd0);
    vready = 1'b1;
    cyc(1);
    vready = 1'b0;
    cyc(1);
    chk("R6 swi cleared by accept", 32'(vvalid), 32'd0);
    i_mask = 1'b0;
    cyc(1);
  endtask

  task automatic t_single();
    flag[pidx(5, 2)] = 1'b1;
    en[pidx(5, 2)] = 1'b1;
    cyc(2);
    chk("R3 pend line5", 32'(pend), 32'h0010);
    chk("R2 line5 addr", 32'(vaddr), 32'(laddr(5)));
    chk("R2 line5 prio", 32'(vprio), 32'd5);
    chk("R10 irq_req high", 32'(irq_req), 32'd1);
    drain();
  endtask

  task automatic t_pairs();
    flag[pidx(11, 0)] = 1'b1;
    en[pidx(11, 3)] = 1'b1;
    cyc(2);
    chk("R3 mismatched pair not pending", 32'(pend), 32'h0);
    chk("R3 no vector", 32'(vvalid), 32'd0);
    flag[pidx(11, 3)] = 1'b1;
    cyc(2);
    chk("R3 pair3 makes line11 pending", 32'(pend), 32'h0400);
    chk("R2 line11 addr", 32'(vaddr), 32'(laddr(11)));
    drain();
  endtask

  task automatic t_winner();
    flag[pidx(16, 1)] = 1'b1; en[pidx(16, 1)] = 1'b1;
    flag[pidx(9, 0)] = 1'b1;  en[pidx(9, 0)] = 1'b1;
    cyc(2);
    chk("R4 line9 beats line16", 32'(vprio), 32'd9);
    chk("R4 line9 addr", 32'(vaddr), 32'(laddr(9)));
    flag[pidx(9, 0)] = 1'b0;
    vready = 1'b1;
    cyc(1);
    vready = 1'b0;
    cyc(1);
    chk("R2 line16 addr", 32'(vaddr), 32'hFFDC);
    chk("R2 line16 prio", 32'(vprio), 32'd16);
    drain();
  endtask

  task automatic t_hold();
    flag[pidx(16, 0)] = 1'b1; en[pidx(16, 0)] = 1'b1;
    cyc(2);
    chk("R9 line16 presented", 32'(vaddr), 32'hFFDC);
    flag[pidx(3, 0)] = 1'b1; en[pidx(3, 0)] = 1'b1;
    cyc(3);
    chk("R9 held despite line3", 32'(vaddr), 32'hFFDC);
    chk("R9 prio held", 32'(vprio), 32'd16);
    vready = 1'b1;
    cyc(1);
    vready = 1'b0;
    chk("R4 line3 after accept", 32'(vaddr), 32'(laddr(3)));
    drain();
  endtask

  task automatic t_mask();
    flag[pidx(7, 1)] = 1'b1; en[pidx(7, 1)] = 1'b1;
    cyc(2);
    chk("R10 irq_req with I clear", 32'(irq_req), 32'd1);
    i_mask = 1'b1;
    cyc(2);
    chk("R5 irq_req low under mask", 32'(irq_req), 32'd0);
    chk("R5 pend still shown", 32'(pend), 32'h0040);
    vready = 1'b1;
    cyc(2);
    vready = 1'b0;
    chk("R5 no vector under mask", 32'(vvalid), 32'd0);
    i_mask = 1'b0;
    cyc(2);
    chk("R5 vector after unmask", 32'(vaddr), 32'(laddr(7)));
    drain();
  endtask

  task automatic t_irq_pin();
    irq_pin_n = 1'b0;
    cyc(5);
    chk("R7 latch after fall", 32'(pend), 32'h0001);
    chk("R7 R2 line1 addr", 32'(vaddr), 32'hFFFA);
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    cyc(4);
    chk("R7 one set per edge", 32'(pend), 32'h0);
    drain();
    irq_mask = 1'b1;
    irq_pin_n = 1'b1;
    cyc(3);
    irq_pin_n = 1'b0;
    cyc(5);
    chk("R7 masked line not pending", 32'(pend), 32'h0);
    irq_mask = 1'b0;
    cyc(1);
    chk("R7 latch kept under mask", 32'(pend), 32'h0001);
    irq_ack = 1'b1;
    cyc(1);
    irq_ack = 1'b0;
    irq_pin_n = 1'b1;
    cyc(3);
    drain();
  endtask

  task automatic t_pll();
    pll_ie = 1'b1;
    pll_lock = 1'b1;
    cyc(2);
    chk("R8 flag on lock gain", 32'(pend), 32'h0002);
    chk("R8 R2 line2 addr", 32'(vaddr), 32'hFFF8);
    pll_ack = 1'b1;
    cyc(1);
    pll_ack = 1'b0;
    cyc(1);
    chk("R8 ack clears", 32'(pend), 32'h0);
    pll_lock = 1'b0;
    cyc(2);
    chk("R8 flag on lock loss", 32'(pend), 32'h0002);
    pll_ie = 1'b0;
    cyc(1);
    chk("R8 enable gates line2", 32'(pend), 32'h0);
    pll_ack = 1'b1;
    cyc(1);
    pll_ack = 1'b0;
    drain();
  endtask

  initial begin
    cyc(2);
    t_reset();
    t_swi();
    t_single();
    t_pairs();
    t_winner();
    t_hold();
    t_mask();
    t_irq_pin();
    t_pll();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule